// File: doc/BRIEF.md
# MSI-X Vector Mask and Pending Controller

This block is the interrupt-delivery side of an MSI-X capability for one PCI function. It keeps a small message table: one entry per vector, holding a 64-bit message address, a 32-bit message data word and a vector-control word. It also keeps a Pending Bit Array (PBA) that software can read but not write. Device logic raises per-vector event pulses. The block turns each event into a message on an address/data output that uses a valid/ready handshake.

Events that arrive while their vector is masked, or while the whole function is masked, are not dropped. Each one sets the vector's pending bit. When the vector is later unmasked, the held event is released. Software reaches the table and the PBA through a simple register port that accepts aligned 32-bit or 64-bit accesses. The enable and function-mask bits sit in a separate 16-bit message-control register.

Top module: `msix_vec_ctrl`

## Requirements
- R1: After reset, every vector's mask bit is 1, all address and data words are 0, every pending bit is 0, message control reads 0 and msg_valid is 0.
- R2: The table base is the byte offset TBL_WORD with bits 2:0 cleared. The PBA base is PBA_WORD with bits 2:0 cleared. The default PBA_WORD of 0x805 places the PBA at byte 0x800, not at 0x805 or at 0x805 shifted right by 3.
- R3: Table entry v occupies 16 bytes at table base + 16*v, in this order: address low (+0), address high (+4), message data (+8), vector control (+12). Vector-control bit 0 is the mask bit, and the other bits of that word read 0.
- R4: With reg_wide set, a 64-bit access at an 8-byte-aligned address covers two adjacent words. The low word is reg_wdata[31:0] or reg_rdata[31:0]. An access with address bits 1:0 not zero, or a 64-bit access with address bit 2 set, writes nothing and reads 0.
- R5: The PBA reads at its base with pending bit v in data bit v. Writes to it are ignored.
- R6: Message control bit 15 is the enable and bit 14 is the function mask. With enable set, the function mask clear and vector v unmasked, an irq[v] pulse sampled at a clock edge makes msg_valid high after the next edge. The message carries entry v's address, entry v's data, and v on msg_vec.
- R7: An event on a masked vector sends no message and sets that vector's pending bit.
- R8: Clearing the mask of a vector whose pending bit is set sends that vector's message. The pending bit clears at the edge where the message is accepted.
- R9: While the function mask is set, no message is launched, whatever the vector masks say, and events set pending bits. Clearing the function mask sends every released pending vector.
- R10: While enable is 0, no message is launched and events are not recorded.
- R11: When several vectors are ready to send, the lowest-numbered one goes first.
- R12: While msg_valid is high and msg_ready is low, msg_valid stays high and msg_addr, msg_data and msg_vec hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for message control |
| cfg_wdata | input | 16 | Message control write value (bit 15 enable, bit 14 function mask) |
| cfg_rdata | output | 16 | Message control read value |
| reg_wr | input | 1 | Table/PBA write strobe |
| reg_addr | input | AW | Byte address of the table/PBA access |
| reg_wide | input | 1 | 1 selects a 64-bit access, 0 a 32-bit access |
| reg_wdata | input | 64 | Write data, low word in bits 31:0 |
| reg_rdata | output | 64 | Combinational read data for reg_addr |
| irq | input | NVEC | One-cycle event pulse per vector |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | The consumer accepts the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| msg_vec | output | VW | Number of the vector being sent |

## Verification
The assertions assume that the consumer raises msg_ready only on its own schedule and never withdraws anything already accepted. They also assume that irq pulses outside the enabled window are legal input, not errors. The bench changes inputs only at the falling edge, holds irq high for exactly one cycle per event, and drives msg_ready high for a single cycle only after it has seen msg_valid. Table writes are made only while no message is in flight, so a held message is never compared against a table entry that changed after it was latched.

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl #(
  parameter int          NVEC     = 4,
  parameter int          AW       = 12,
  parameter logic [31:0] TBL_WORD = 32'h0000_0000,
  parameter logic [31:0] PBA_WORD = 32'h0000_0805,
  localparam int         VW       = (NVEC > 1) ? $clog2(NVEC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [15:0]     cfg_wdata,
  output logic [15:0]     cfg_rdata,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_wide,
  input  logic [63:0]     reg_wdata,
  output logic [63:0]     reg_rdata,
  input  logic [NVEC-1:0] irq,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [63:0]     msg_addr,
  output logic [31:0]     msg_data,
  output logic [VW-1:0]   msg_vec
);
  localparam logic [AW-1:0] TBL_OFF = AW'(TBL_WORD & ~32'h7);
  localparam logic [AW-1:0] PBA_OFF = AW'(PBA_WORD & ~32'h7);
  localparam logic [AW:0]   TBL_END = {1'b0, TBL_OFF} + (AW+1)'(NVEC * 16);

  logic [31:0]     a_lo [NVEC];
  logic [31:0]     a_hi [NVEC];
  logic [31:0]     dat  [NVEC];
  logic [NVEC-1:0] mask, pend, pend_n, elig;
  logic            en, fm, any;
  logic [VW-1:0]   pick;

  wire [AW-1:0] toff   = reg_addr - TBL_OFF;
  wire          in_tbl = ({1'b0, reg_addr} >= {1'b0, TBL_OFF}) && ({1'b0, reg_addr} < TBL_END);
  wire          algn   = (reg_addr[1:0] == 2'b00) && !(reg_wide && reg_addr[2]);
  wire [VW-1:0] wvec   = VW'(toff >> 4);
  wire [1:0]    wsel   = toff[3:2];
  wire          wr_ok  = reg_wr && algn && in_tbl;
  wire          accept = msg_valid && msg_ready;

  assign cfg_rdata = {en, fm, 14'b0};

  function automatic logic [31:0] word_at(input logic [VW-1:0] v, input logic [1:0] s);
    case (s)
      2'd0:    return a_lo[v];
      2'd1:    return a_hi[v];
      2'd2:    return dat[v];
      default: return {31'b0, mask[v]};
    endcase
  endfunction

  always_comb begin
    reg_rdata = '0;
    if (algn && in_tbl) begin
      reg_rdata[31:0] = word_at(wvec, wsel);
      if (reg_wide) reg_rdata[63:32] = word_at(wvec, wsel | 2'b01);
    end else if (algn && reg_addr == PBA_OFF) begin
      reg_rdata[31:0] = 32'(pend);
    end
  end

  logic [3:0]  hit;
  logic [31:0] wv [4];
  always_comb begin
    for (int s = 0; s < 4; s++) begin
      hit[s] = wr_ok && ((2'(s) == wsel) || (reg_wide && 2'(s) == (wsel | 2'b01)));
      wv[s]  = (2'(s) == wsel) ? reg_wdata[31:0] : reg_wdata[63:32];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int v = 0; v < NVEC; v++) begin
        a_lo[v] <= '0;
        a_hi[v] <= '0;
        dat[v]  <= '0;
      end
      mask <= '1;
    end else begin
      for (int v = 0; v < NVEC; v++) begin
        if (wvec == VW'(v)) begin
          if (hit[0]) a_lo[v]  <= wv[0];
          if (hit[1]) a_hi[v]  <= wv[1];
          if (hit[2]) dat[v]   <= wv[2];
          if (hit[3]) mask[v]  <= wv[3][0];
        end
      end
    end
  end

  assign elig = pend & ~mask & {NVEC{en && !fm}};
  assign any  = |elig;

  always_comb begin
    pick = '0;
    for (int i = NVEC - 1; i >= 0; i--)
      if (elig[i]) pick = VW'(i);
  end

  always_comb begin
    pend_n = pend;
    if (accept) pend_n[msg_vec] = 1'b0;
    if (en) pend_n = pend_n | irq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en        <= 1'b0;
      fm        <= 1'b0;
      pend      <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
      msg_vec   <= '0;
    end else begin
      if (cfg_we) begin
        en <= cfg_wdata[15];
        fm <= cfg_wdata[14];
      end
      pend <= pend_n;
      if (accept) begin
        msg_valid <= 1'b0;
      end else if (!msg_valid && any) begin
        msg_valid <= 1'b1;
        msg_vec   <= pick;
        msg_addr  <= {a_hi[pick], a_lo[pick]};
        msg_data  <= dat[pick];
      end
    end
  end
endmodule

module msix_vec_ctrl_chk #(
  parameter int NVEC = 4,
  parameter int VW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            msg_valid,
  input logic            msg_ready,
  input logic [63:0]     msg_addr,
  input logic [31:0]     msg_data,
  input logic [VW-1:0]   msg_vec,
  input logic [NVEC-1:0] irq,
  input logic [NVEC-1:0] pend,
  input logic [NVEC-1:0] mask,
  input logic [NVEC-1:0] elig,
  input logic            en,
  input logic            fm
);
  // R12
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data) && $stable(msg_vec));

  // R9
  gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(en && !fm));

  // R7
  vec_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> ((($past(mask) >> msg_vec) & NVEC'(1)) == '0));

  // R11
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> (($past(elig) & ((NVEC'(1) << msg_vec) - NVEC'(1))) == '0));

  // R8
  pend_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready && ((irq >> msg_vec) & NVEC'(1)) == '0
      |=> ((pend >> $past(msg_vec)) & NVEC'(1)) == '0);

  // R10
  no_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pend & ~$past(pend)) == '0);
endmodule

bind msix_vec_ctrl msix_vec_ctrl_chk #(.NVEC(NVEC), .VW(VW)) chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .msg_vec(msg_vec), .irq(irq),
  .pend(pend), .mask(mask), .elig(elig), .en(en), .fm(fm)
);

// File: tb/msix_vec_ctrl_test.sv
`timescale 1ns/1ps
module msix_vec_ctrl_test;
  localparam int NVEC = 4;
  localparam int AW   = 12;
  localparam int VW   = 2;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            cfg_we = 0;
  logic [15:0]     cfg_wdata = 0;
  logic [15:0]     cfg_rdata;
  logic            reg_wr = 0;
  logic [AW-1:0]   reg_addr = 0;
  logic            reg_wide = 0;
  logic [63:0]     reg_wdata = 0;
  logic [63:0]     reg_rdata;
  logic [NVEC-1:0] irq = 0;
  logic            msg_valid;
  logic            msg_ready = 0;
  logic [63:0]     msg_addr;
  logic [31:0]     msg_data;
  logic [VW-1:0]   msg_vec;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  msix_vec_ctrl #(.NVEC(NVEC), .AW(AW)) uut (.*);

  function automatic logic [63:0] exp_addr(int v);
    return {32'h0000_00F0 + 32'(v), 32'hA000_0000 + 32'(v * 16)};
  endfunction
  function automatic logic [31:0] exp_data(int v);
    return 32'h0000_D000 + 32'(v);
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input bit w, input logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_wide = w; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input bit w, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_wide = w;
    #1 d = reg_rdata;
  endtask

  task automatic cfg(input logic [15:0] d);
    @(negedge clk);
    cfg_wdata = d; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse(input logic [NVEC-1:0] m);
    @(negedge clk);
    irq = m;
    @(negedge clk);
    irq = 0;
  endtask

  task automatic quiet(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(tag, 64'(msg_valid), 64'd0);
    end
  endtask

  task automatic take(input string tag, input int v);
    for (int i = 0; i < 20 && !msg_valid; i++) @(negedge clk);
    chk({tag, " valid"}, 64'(msg_valid), 64'd1);
    chk({tag, " vec"},   64'(msg_vec),   64'(v));
    chk({tag, " addr"},  msg_addr,       exp_addr(v));
    chk({tag, " data"},  64'(msg_data),  64'(exp_data(v)));
    msg_ready = 1;
    @(negedge clk);
    msg_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    @(negedge clk);
    chk("R1 cfg", 64'(cfg_rdata), 64'd0);
    chk("R1 valid", 64'(msg_valid), 64'd0);
    for (int v = 0; v < NVEC; v++) begin
      rd(AW'(v * 16 + 12), 0, d); chk("R1 mask", d, 64'd1);
      rd(AW'(v * 16), 1, d);      chk("R1 addr", d, 64'd0);
    end
    rd(12'h800, 0, d); chk("R1 pba", d, 64'd0);

    // R3 R4 program and read back
    for (int v = 0; v < NVEC; v++) begin
      wr(AW'(v * 16), 1, exp_addr(v));
      wr(AW'(v * 16 + 8), 0, 64'(exp_data(v)));
      wr(AW'(v * 16 + 12), 0, 64'hFFFF_FFFF);
    end
    for (int v = 0; v < NVEC; v++) begin
      rd(AW'(v * 16), 0, d);     chk("R3 lo", d, {32'd0, exp_addr(v)[31:0]});
      rd(AW'(v * 16 + 4), 0, d); chk("R3 hi", d, {32'd0, exp_addr(v)[63:32]});
      rd(AW'(v * 16 + 12), 0, d); chk("R3 ctrl", d, 64'd1);
      rd(AW'(v * 16 + 8), 1, d); chk("R4 wide", d, {32'd1, exp_data(v)});
    end

    // R4 misaligned ignored
    wr(12'h014, 1, 64'h1111_1111_2222_2222);
    wr(12'h011, 0, 64'h3333_3333);
    rd(12'h010, 1, d); chk("R4 misaligned write", d, exp_addr(1));
    rd(12'h014, 1, d); chk("R4 misaligned read", d, 64'd0);

    // R5 R2 PBA
    wr(12'h800, 0, 64'hF);
    rd(12'h800, 0, d); chk("R5 pba ro", d, 64'd0);

    // R7 masked events
    cfg(16'h8000);
    chk("R6 cfg", 64'(cfg_rdata), 64'h8000);
    pulse(4'hF);
    quiet("R7 no msg", 6);
    rd(12'h800, 0, d); chk("R7 pba", d, 64'hF);
    rd(12'h805, 0, d); chk("R2 unaligned pba", d, 64'd0);
    rd(12'h100, 0, d); chk("R2 not shifted", d, 64'd0);
    wr(12'h800, 0, 64'h0);
    rd(12'h800, 0, d); chk("R5 pba write ignored", d, 64'hF);

    // R8 unmask one vector
    wr(12'h02C, 0, 64'h0);
    take("R8 unmask", 2);
    @(negedge clk);
    rd(12'h800, 0, d); chk("R8 pba cleared", d, 64'hB);

    // R9 function mask
    cfg(16'hC000);
    for (int v = 0; v < NVEC; v++) wr(AW'(v * 16 + 12), 0, 64'h0);
    quiet("R9 blocked", 5);
    pulse(4'h4);
    quiet("R9 blocked event", 3);
    rd(12'h800, 0, d); chk("R9 pba", d, 64'hF);
    cfg(16'h8000);
    // R11 ascending release
    for (int v = 0; v < NVEC; v++) take("R9 R11 release", v);
    quiet("R9 drained", 3);
    rd(12'h800, 0, d); chk("R9 pba empty", d, 64'd0);

    // R6 latency per vector
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      irq = NVEC'(1) << v;
      @(negedge clk);
      irq = 0;
      chk("R6 not yet", 64'(msg_valid), 64'd0);
      @(negedge clk);
      chk("R6 valid", 64'(msg_valid), 64'd1);
      take("R6 msg", v);
    end

    // R12 backpressure, R11 vec0 queued behind vec3
    pulse(4'h8);
    @(negedge clk);
    pulse(4'h1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R12 hold valid", 64'(msg_valid), 64'd1);
      chk("R12 hold vec", 64'(msg_vec), 64'd3);
      chk("R12 hold addr", msg_addr, exp_addr(3));
    end
    take("R12 accept", 3);
    take("R11 next", 0);

    // R10 disabled
    cfg(16'h0000);
    pulse(4'hF);
    quiet("R10 no msg", 4);
    rd(12'h800, 0, d); chk("R10 not recorded", d, 64'd0);
    cfg(16'h8000);
    quiet("R10 nothing after enable", 4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule